// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs management read and write transactions to an external PHY over a two-wire serial link. One wire is the management clock (`mdc_o`). The other is a shared data line, split at the block edge into an output value, an output enable and an input. The host presents a PHY address, a register number, a direction flag and write data, then pulses `start_i`. The block latches the request and shifts out a complete frame. For reads, it collects the PHY's answer and presents it with a one-cycle `done_o` pulse.

The management clock is derived from the system clock. Each half period lasts `HALF_CYC` system cycles, and the smallest legal value is 1. Every frame bit therefore takes `2*HALF_CYC` system cycles: a low half, in which the block changes the data it drives, followed by a high half. Read bits are captured from `mdio_i` on the system edge that ends the high half. Write frames are 65 bits long and read frames are 64 bits long. Bit index 0 is the first preamble bit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Bit indices 0 to 31 of every frame are driven (`mdio_oe_o`=1) with `mdio_o`=1.
- R2: Bits 32 and 33 are driven as 0 then 1. Bits 34 and 35 are driven as 1,0 for a read (`rd_i`=1) and as 0,1 for a write.
- R3: Bits 36 to 40 carry the latched PHY address and bits 41 to 45 carry the latched register number, both driven MSB first.
- R4: In a write, bits 46 and 47 are released (`mdio_oe_o`=0, `mdio_o`=0) and bits 48 to 63 drive the write data MSB first.
- R5: In a read, bit 46 is released and bits 47 to 62 are released and sampled. The first sampled bit lands in `rdata_o[15]`. `rdata_o` takes the new word in the same cycle that `done_o` is high.
- R6: The last bit of each frame (63 for a read, 64 for a write) is a released clock. Whenever `busy_o` is low, `mdc_o`, `mdio_o` and `mdio_oe_o` are all 0.
- R7: While busy, `mdc_o` is low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles in every bit. `mdio_o` and `mdio_oe_o` change only at the start of a low half.
- R8: `busy_o` rises in the cycle after `start_i` is sampled while idle and stays high until the frame ends. A `start_i` sampled while busy is ignored, and the latched request does not change.
- R9: `done_o` is high for exactly one cycle, the first cycle after the last bit ends, and `busy_o` is low in that same cycle. A start sampled in the done cycle begins a new frame.
- R10: In every cycle where `rst_n` was low at the previous edge, all outputs are 0.
- R11: Write transactions leave `rdata_o` unchanged. `mdio_i` has no effect outside the read sampling points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request pulse, taken only while idle |
| rd_i | input | 1 | 1 = read transaction, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register number |
| wdata_i | input | 16 | Data for write transactions |
| rdata_o | output | 16 | Word returned by the last read |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| busy_o | output | 1 | Transaction in progress |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pin |

## Verification
Two events can fall in the same cycle: the completion of one frame and the acceptance of the next request. To provoke this, the bench holds `start_i` high with fresh fields across the whole of a running frame, so the request is refused while busy and taken at the edge that ends the done cycle. The bench's behavioural frame model checks this on every clock. It expects the old frame's `done_o` and final read word, followed by a new frame that starts with a low clock half and the new fields. Any stale bit or shifted phase at that seam is reported against the requirement that owns the bit.

// File: rtl/mdio_mgmt_pkg.sv
// Shared constants and the latched-request type for the management master.
// Frame bit indices are fixed by the serial protocol and decoded by the encoder,
// the sequencer and the read capture, so they live here once.
package mdio_mgmt_pkg;
    localparam int FIELD_W = 5;
    localparam int DATA_W  = 16;
    localparam int IDX_W   = 7;

    localparam logic [IDX_W-1:0] IX_SOF      = 7'd32;  // start code 0,1
    localparam logic [IDX_W-1:0] IX_OP       = 7'd34;  // opcode pair
    localparam logic [IDX_W-1:0] IX_PHY      = 7'd36;  // PHY address MSB
    localparam logic [IDX_W-1:0] IX_REG      = 7'd41;  // register number MSB
    localparam logic [IDX_W-1:0] IX_TA       = 7'd46;  // first turnaround bit
    localparam logic [IDX_W-1:0] IX_RD_FIRST = 7'd47;  // first sampled bit
    localparam logic [IDX_W-1:0] IX_RD_LAST  = 7'd62;  // last sampled bit
    localparam logic [IDX_W-1:0] IX_WR_FIRST = 7'd48;  // first write data bit
    localparam logic [IDX_W-1:0] IX_RD_END   = 7'd63;  // read trailing clock
    localparam logic [IDX_W-1:0] IX_WR_END   = 7'd64;  // write trailing clock

    typedef struct packed {
        logic               rd;
        logic [FIELD_W-1:0] phy;
        logic [FIELD_W-1:0] regn;
        logic [DATA_W-1:0]  wdata;
    } mgmt_req_t;
endpackage

// File: rtl/mdio_clk_phase.sv
// Management clock phase generator.
// Produces mdc (low half first) and a strobe on the last system cycle of each
// half. Assumes HALF_CYC >= 1; idles low with its counter cleared while !run.
module mdio_clk_phase #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic half_end
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    // Half-period level: toggles at each half end, forced low when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) mdc <= 1'b0;
        else if (half_end)  mdc <= ~mdc;
    end

    generate
        if (HALF_CYC == 1) begin : g_single
            // Every busy cycle is a complete half period.
            assign half_end = run;
        end else begin : g_count
            logic [CW-1:0] cnt;
            localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);

            // Cycle position inside the current half period.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) cnt <= '0;
                else if (half_end)  cnt <= '0;
                else                cnt <= cnt + 1'b1;
            end

            assign half_end = run && (cnt == CNT_LAST);
        end
    endgenerate
endmodule

// File: rtl/mdio_frame_enc.sv
// Frame bit encoder: maps a bit index and the latched request to the
// output-enable and the data value for that bit. Purely combinational;
// a released bit always reports value 0.
module mdio_frame_enc
    import mdio_mgmt_pkg::*;
(
    input  mgmt_req_t        req,
    input  logic [IDX_W-1:0] idx,
    output logic             drive,
    output logic             value
);
    logic [2:0] fsel;
    logic [3:0] dsel;

    // Bit selectors for the MSB-first fields.
    always_comb begin
        fsel = 3'd0;
        dsel = 4'd0;
        if (idx >= IX_REG)      fsel = 3'(IX_REG + 7'd4 - idx);
        else if (idx >= IX_PHY) fsel = 3'(IX_PHY + 7'd4 - idx);
        if (idx >= IX_WR_FIRST) dsel = 4'(IX_WR_FIRST + 7'd15 - idx);
    end

    // Per-index drive decision and value.
    always_comb begin
        drive = 1'b0;
        value = 1'b0;
        if (idx < IX_SOF) begin
            drive = 1'b1;
            value = 1'b1;
        end else if (idx < IX_OP) begin
            drive = 1'b1;
            value = (idx == IX_SOF + 7'd1);
        end else if (idx < IX_PHY) begin
            drive = 1'b1;
            value = (idx == IX_OP) ? req.rd : ~req.rd;
        end else if (idx < IX_REG) begin
            drive = 1'b1;
            value = req.phy[fsel];
        end else if (idx < IX_TA) begin
            drive = 1'b1;
            value = req.regn[fsel];
        end else if (!req.rd && idx >= IX_WR_FIRST && idx < IX_WR_END) begin
            drive = 1'b1;
            value = req.wdata[dsel];
        end
    end
endmodule

// File: rtl/mdio_rd_capture.sv
// Read data capture: shifts the input pin in MSB first on each sample strobe
// and copies the assembled word to the output on commit. Assumes shift and
// commit never coincide.
module mdio_rd_capture
    import mdio_mgmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              commit,
    input  logic              din,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] shreg;

    // Serial-in shift register for the sampled bits.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (shift_en) shreg <= {shreg[DATA_W-2:0], din};
    end

    // Holding register for the last completed read.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= '0;
        else if (commit) rdata <= shreg;
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
// Management frame master top level.
// Latches a request on start while idle, steps through the frame bits on the
// clock phase generator's bit strobe, and pulses done after the trailing bit.
// Assumes HALF_CYC >= 1. Outputs are forced to 0 while idle.
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic [4:0]  phy_addr_i,
    input  logic [4:0]  reg_addr_i,
    input  logic [15:0] wdata_i,
    output logic [15:0] rdata_o,
    output logic        done_o,
    output logic        busy_o,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe_o,
    input  logic        mdio_i
);
    mgmt_req_t        req_q;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_last;
    logic             busy;
    logic             done;
    logic             mdc;
    logic             half_end;
    logic             bit_end;
    logic             enc_drive;
    logic             enc_value;
    logic             shift_en;
    logic             commit;

    mdio_clk_phase #(.HALF_CYC(HALF_CYC)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .half_end (half_end)
    );

    assign bit_end  = half_end & mdc;
    assign idx_last = req_q.rd ? IX_RD_END : IX_WR_END;

    // Transaction sequencer: accept, advance bit index, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            idx   <= '0;
            req_q <= '0;
        end else begin
            done <= 1'b0;
            if (start_i && !busy) begin
                busy  <= 1'b1;
                idx   <= '0;
                req_q <= '{rd: rd_i, phy: phy_addr_i, regn: reg_addr_i, wdata: wdata_i};
            end else if (busy && bit_end) begin
                if (idx == idx_last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    idx  <= '0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    mdio_frame_enc u_enc (
        .req   (req_q),
        .idx   (idx),
        .drive (enc_drive),
        .value (enc_value)
    );

    assign shift_en = busy && bit_end && req_q.rd &&
                      (idx >= IX_RD_FIRST) && (idx <= IX_RD_LAST);
    assign commit   = busy && bit_end && req_q.rd && (idx == IX_RD_END);

    mdio_rd_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .commit   (commit),
        .din      (mdio_i),
        .rdata    (rdata_o)
    );

    assign busy_o    = busy;
    assign done_o    = done;
    assign mdc_o     = mdc;
    assign mdio_oe_o = busy & enc_drive;
    assign mdio_o    = busy & enc_drive & enc_value;
endmodule

// File: rtl/mdio_mgmt_chk.sv
// Protocol checker for the management master, bound to every instance.
// Watches only the top-level ports; half-period length is checked with a
// run-length counter instead of a deep $past.
module mdio_mgmt_chk #(
    parameter int HALF_CYC = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [15:0] rdata_o,
    input logic        done_o,
    input logic        busy_o,
    input logic        mdc_o,
    input logic        mdio_o,
    input logic        mdio_oe_o
);
    logic        mdc_q;
    logic        busy_q;
    logic [15:0] run_len;

    // Previous-cycle copies and length of the current clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_q   <= 1'b0;
            busy_q  <= 1'b0;
            run_len <= '0;
        end else begin
            mdc_q   <= mdc_o;
            busy_q  <= busy_o;
            if (!busy_o)             run_len <= '0;
            else if (mdc_o != mdc_q) run_len <= 16'd1;
            else                     run_len <= run_len + 16'd1;
        end
    end

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mdc_o && !mdio_o && !mdio_oe_o));

    // R7
    half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (mdc_o != mdc_q)) |-> (run_len == 16'(HALF_CYC)));

    // R7
    drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc_o) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(rdata_o));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .rdata_o   (rdata_o),
    .done_o    (done_o),
    .busy_o    (busy_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/tb_mdio_mgmt_master.sv
// Bench: behavioural frame model compared against the design on every clock.
module tb_mdio_mgmt_master;
    localparam int HALF = 2;
    localparam int BITC = 2 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [4:0]  phy_addr_i = '0;
    logic [4:0]  reg_addr_i = '0;
    logic [15:0] wdata_i = '0;
    logic [15:0] rdata_o;
    logic        done_o;
    logic        busy_o;
    logic        mdc_o;
    logic        mdio_o;
    logic        mdio_oe_o;
    logic        mdio_i = 1'b0;

    always #10 clk = ~clk;

    mdio_mgmt_master #(.HALF_CYC(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
        .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .done_o(done_o), .busy_o(busy_o), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit in_reset = 1'b1;

    // model state
    bit [1:0]    frame_q[$];
    bit          m_busy = 1'b0;
    bit          m_done = 1'b0;
    bit          m_rd = 1'b0;
    bit          last_rd = 1'b0;
    int          m_t = 0;
    logic [15:0] m_rdata = '0;
    logic [15:0] m_sh = '0;
    logic [15:0] phy_word = 16'h0000;
    logic [15:0] noise = 16'hACE1;

    task automatic push_bit(input bit drv, input bit val);
        frame_q.push_back({drv, val & drv});
    endtask

    // Frame built from the requirements (R1 to R6).
    task automatic build_frame(input bit rd, input logic [4:0] pa,
                               input logic [4:0] ra, input logic [15:0] wd);
        frame_q.delete();
        for (int i = 0; i < 32; i++) push_bit(1, 1);
        push_bit(1, 0); push_bit(1, 1);
        if (rd) begin push_bit(1, 1); push_bit(1, 0); end
        else    begin push_bit(1, 0); push_bit(1, 1); end
        for (int i = 4; i >= 0; i--) push_bit(1, pa[i]);
        for (int i = 4; i >= 0; i--) push_bit(1, ra[i]);
        if (rd) begin
            push_bit(0, 0);
            for (int i = 0; i < 16; i++) push_bit(0, 0);
        end else begin
            push_bit(0, 0); push_bit(0, 0);
            for (int i = 15; i >= 0; i--) push_bit(1, wd[i]);
        end
        push_bit(0, 0);
    endtask

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        cyc++;
        in_reset = !rst_n;
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_rdata = '0; m_sh = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                if (m_rd && (m_t % BITC) == BITC - 1 &&
                    (m_t / BITC) >= 47 && (m_t / BITC) <= 62)
                    m_sh = {m_sh[14:0], mdio_i};
                m_t++;
                if (m_t == BITC * frame_q.size()) begin
                    m_busy = 0;
                    m_done = 1;
                    if (m_rd) m_rdata = m_sh;
                end
            end else if (start_i) begin
                build_frame(rd_i, phy_addr_i, reg_addr_i, wdata_i);
                m_busy = 1; m_t = 0; m_rd = rd_i; last_rd = rd_i;
            end
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s act=%h exp=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic string bit_tag(input int b, input bit rd);
        if (b < 32) return "R1";
        if (b < 36) return "R2";
        if (b < 46) return "R3";
        if (rd) return (b < 63) ? "R5" : "R6";
        return (b < 64) ? "R4" : "R6";
    endfunction

    // Compare away from the active edge; also play the PHY on mdio_i.
    always @(negedge clk) begin
        int  b;
        bit  e_mdc, e_oe, e_do;
        string t;
        b = m_busy ? (m_t / BITC) : 0;
        e_mdc = m_busy && ((m_t % BITC) >= HALF);
        e_oe  = m_busy && frame_q[b][1];
        e_do  = m_busy && frame_q[b][0];
        if (cyc > 0) begin
            t = in_reset ? "R10" : (m_busy ? bit_tag(b, m_rd) : "R6");
            chk(in_reset ? "R10" : (m_busy ? "R7" : "R6"), "mdc", 16'(mdc_o), 16'(e_mdc));
            chk(t, "oe", 16'(mdio_oe_o), 16'(e_oe));
            chk(t, "mdio_o", 16'(mdio_o), 16'(e_do));
            chk(in_reset ? "R10" : "R8", "busy", 16'(busy_o), 16'(m_busy));
            chk(in_reset ? "R10" : "R9", "done", 16'(done_o), 16'(m_done));
            chk(in_reset ? "R10" : (last_rd ? "R5" : "R11"), "rdata", rdata_o, m_rdata);
        end
        noise = {noise[14:0], noise[15] ^ noise[13] ^ noise[12] ^ noise[10]};
        if (m_busy && m_rd && b >= 47 && b <= 62) mdio_i = phy_word[15 - (b - 47)];
        else mdio_i = noise[0];   // R11: garbage outside sample points
    end

    task automatic issue(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd);
        @(negedge clk);
        rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd; start_i = 1;
        @(negedge clk);
        start_i = 0;
        rd_i = ~rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;  // R8: latched
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R8 act=running exp=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);           // R10 reset state
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R4 write, mixed fields
        issue(0, 5'h15, 5'h0A, 16'hA5C3); wait_idle();
        // R5 read
        phy_word = 16'h3C96;
        issue(1, 5'h01, 5'h02, 16'h0000); wait_idle();
        // R11 write after read keeps rdata
        issue(0, 5'h00, 5'h1F, 16'hFFFF); wait_idle();
        // R5 read all ones, then all zeros; R3 extreme addresses
        phy_word = 16'hFFFF;
        issue(1, 5'h1F, 5'h1F, 16'h1234); wait_idle();
        phy_word = 16'h0000;
        issue(1, 5'h00, 5'h00, 16'hFFFF); wait_idle();

        // R8 start during busy is ignored
        phy_word = 16'h8001;
        issue(1, 5'h0C, 5'h11, 16'h0000);
        repeat (40) @(negedge clk);
        rd_i = 0; phy_addr_i = 5'h1E; reg_addr_i = 5'h03; wdata_i = 16'h5555; start_i = 1;
        @(negedge clk);
        start_i = 0;
        wait_idle();

        // R9 back-to-back: request held through busy, accepted in done cycle
        phy_word = 16'hC3A5;
        issue(1, 5'h0A, 5'h05, 16'h0000);
        rd_i = 0; phy_addr_i = 5'h11; reg_addr_i = 5'h0E; wdata_i = 16'h6B2D; start_i = 1;
        while (!done_o) @(negedge clk);
        @(negedge clk);
        start_i = 0;
        wait_idle();

        // R10 reset in mid-frame
        issue(0, 5'h07, 5'h09, 16'h0F0F);
        repeat (30) @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        phy_word = 16'h7E81;
        issue(1, 5'h12, 5'h04, 16'h0000); wait_idle();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule